// File: doc/BRIEF.md
# DMA Bus Cycle Sequencer

This block is the timing engine of a single DMA controller. It waits in an idle state and looks at the channel request lines on each falling clock edge. When it sees an unmasked request, it picks the lowest-numbered requesting channel and raises a bus hold request. It then stays in a hold-pending state until the processor grants the bus. After the grant it steps through a fixed series of one-clock working states that drive the memory and I/O strobes for exactly one transfer.

For I/O-to-memory and memory-to-I/O transfers, the two strobes of a pair are asserted together, and data does not pass through the block. A memory-to-memory copy uses its own eight-state sequence: a read half followed by a write half. The `ready` input can stretch each transfer with wait states. A compressed-timing option shortens the normal sequence.

At the end of a transfer the block pulses a done signal together with the serviced channel number. The neighbouring address/count block uses this pulse to step its registers. The block then returns to idle.

Top module: `dma_bus_seq`

## Requirements
- R1: An asynchronous reset and a synchronous master clear (`mclr` high at a rising edge) both put the sequencer in idle at that edge. In idle, `hold_req`, `dack`, all four strobes and `xfer_done` are low.
- R2: In idle, the request lines are captured on the falling clock edge. A request that is high only around a falling edge, and low again before the next rising edge, still starts a service at that rising edge.
- R3: Among captured requests whose `dmask` bit is 0, the lowest-numbered channel is served. A channel whose `dmask` bit is 1 never starts a service, and `dmask` = 4'hF keeps the block idle.
- R4: In the hold-pending state, `hold_req` is high and `dack` is all zero. The block stays in this state for as long as `hold_ack` is low at the rising edge.
- R5: In normal timing, the working states run S1, S2, S3, S4, each one clock long. `dack` is one-hot on the served channel in every working state. The strobe pair is active in S3, in any wait state and in S4. `hold_req` stays high until the block returns to idle.
- R6: In normal timing, when `ready` is low at the rising edge that ends S3, one wait state is inserted. The block keeps inserting wait states until `ready` is high at an edge, and then moves to S4.
- R7: With `compress` = 1 at service start, the working states run S2 then S4, and S1 and S3 are skipped. Wait states are inserted between S2 and S4 while `ready` is low. The strobe pair is active in S2, in any wait state and in S4.
- R8: `xfer_kind` is captured at service start and selects the strobes as follows. 2'b00 drives `ior` with `memw`. 2'b01 drives `memr` with `iow`. 2'b11 runs the normal states with all strobes low.
- R9: `xfer_kind` = 2'b10 runs a memory-to-memory copy through S11–S14 and then S21–S24, regardless of `compress`. `memr` is active in S13, in its wait states and in S14. `memw` is active in S23, in its wait states and in S24. Wait states follow S13 and S23 while `ready` is low.
- R10: `xfer_done` is high for exactly one clock, in S4 or S24, and `done_ch` then carries the served channel number. On the following clock the block is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mclr | input | 1 | Synchronous master clear |
| dreq | input | NCH | Channel request lines |
| dmask | input | NCH | Per-channel mask, 1 blocks the channel |
| hold_ack | input | 1 | Bus grant from the processor |
| ready | input | 1 | Low to insert wait states |
| compress | input | 1 | Compressed timing select |
| xfer_kind | input | 2 | Transfer type select |
| hold_req | output | 1 | Bus hold request |
| dack | output | NCH | One-hot channel acknowledge |
| ior | output | 1 | I/O read strobe |
| iow | output | 1 | I/O write strobe |
| memr | output | 1 | Memory read strobe |
| memw | output | 1 | Memory write strobe |
| xfer_done | output | 1 | One-clock end-of-transfer pulse |
| done_ch | output | CHW | Channel number that goes with `xfer_done` |

## Verification
The assertions check on every cycle that the block stays in hold-pending while there is no grant, and that a wait state follows S3 and S13 when `ready` is low. They also check that compressed timing never visits S3, that the read half hands over to the write half, and that master clear lands in idle. At the output pins they check that `dack` is one-hot only under `hold_req`, that the strobe pairs are never crossed, and that `xfer_done` is a single-clock pulse. Only the bench scenarios can show that the strobes appear in the right states for each transfer kind, and that falling-edge capture starts a service from a short pulse. The same holds for fixed priority under masking and for the exact cycle count of each sequence.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

    typedef enum logic [4:0] {
        ST_SI  = 5'd0,
        ST_S0  = 5'd1,
        ST_S1  = 5'd2,
        ST_S2  = 5'd3,
        ST_S3  = 5'd4,
        ST_SW  = 5'd5,
        ST_S4  = 5'd6,
        ST_S11 = 5'd7,
        ST_S12 = 5'd8,
        ST_S13 = 5'd9,
        ST_SW1 = 5'd10,
        ST_S14 = 5'd11,
        ST_S21 = 5'd12,
        ST_S22 = 5'd13,
        ST_S23 = 5'd14,
        ST_SW2 = 5'd15,
        ST_S24 = 5'd16
    } seq_state_e;

    typedef enum logic [1:0] {
        KIND_IO2MEM  = 2'b00,
        KIND_MEM2IO  = 2'b01,
        KIND_MEM2MEM = 2'b10,
        KIND_NOSTRB  = 2'b11
    } xfer_kind_e;

endpackage

// File: rtl/dma_req_sample.sv
module dma_req_sample #(
    parameter int NCH = 4,
    parameter int CHW = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] dreq,
    input  logic [NCH-1:0] dmask,
    output logic           pend,
    output logic [CHW-1:0] win_ch
);

    logic [NCH-1:0] fall_d, fall_q;
    logic [NCH-1:0] live;
    logic [NCH:0]   below;
    logic [NCH-1:0] take;

    always_comb begin
        fall_d = dreq;
    end

    // Requests are captured on the falling edge.
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) fall_q <= '0;
        else        fall_q <= fall_d;
    end

    assign live     = fall_q & ~dmask;
    assign below[0] = 1'b0;

    generate
        for (genvar g = 0; g < NCH; g++) begin : g_prio
            assign take[g]    = live[g] & ~below[g];
            assign below[g+1] = below[g] | live[g];
        end
    endgenerate

    always_comb begin
        win_ch = '0;
        for (int i = 0; i < NCH; i++) begin
            if (take[i]) win_ch = win_ch | CHW'(i);
        end
    end

    assign pend = below[NCH];

    p_grant_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(take));

endmodule

// File: rtl/dma_seq_fsm.sv
module dma_seq_fsm
    import dma_seq_pkg::*;
#(
    parameter int CHW = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           mclr,
    input  logic           pend,
    input  logic [CHW-1:0] win_ch,
    input  logic           hold_ack,
    input  logic           ready,
    input  logic           compress,
    input  logic [1:0]     xfer_kind,
    output seq_state_e     state_q,
    output logic [CHW-1:0] ch_q,
    output xfer_kind_e     kind_q,
    output logic           comp_q
);

    typedef struct packed {
        seq_state_e     st;
        logic [CHW-1:0] ch;
        xfer_kind_e     kind;
        logic           comp;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_SI: begin
                if (pend) begin
                    r_d.st   = ST_S0;
                    r_d.ch   = win_ch;
                    r_d.kind = xfer_kind_e'(xfer_kind);
                    r_d.comp = compress;
                end
            end
            ST_S0: begin
                if (hold_ack) begin
                    if (r_q.kind == KIND_MEM2MEM) r_d.st = ST_S11;
                    else if (r_q.comp)            r_d.st = ST_S2;
                    else                          r_d.st = ST_S1;
                end
            end
            ST_S1:  r_d.st = ST_S2;
            ST_S2: begin
                if (r_q.comp) r_d.st = ready ? ST_S4 : ST_SW;
                else          r_d.st = ST_S3;
            end
            ST_S3, ST_SW: r_d.st = ready ? ST_S4 : ST_SW;
            ST_S4:  r_d.st = ST_SI;
            ST_S11: r_d.st = ST_S12;
            ST_S12: r_d.st = ST_S13;
            ST_S13, ST_SW1: r_d.st = ready ? ST_S14 : ST_SW1;
            ST_S14: r_d.st = ST_S21;
            ST_S21: r_d.st = ST_S22;
            ST_S22: r_d.st = ST_S23;
            ST_S23, ST_SW2: r_d.st = ready ? ST_S24 : ST_SW2;
            ST_S24: r_d.st = ST_SI;
            default: r_d.st = ST_SI;
        endcase
        if (mclr) r_d.st = ST_SI;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: ST_SI, ch: '0, kind: KIND_IO2MEM, comp: 1'b0};
        else        r_q <= r_d;
    end

    assign state_q = r_q.st;
    assign ch_q    = r_q.ch;
    assign kind_q  = r_q.kind;
    assign comp_q  = r_q.comp;

    p_mclr_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mclr |=> (state_q == ST_SI));

    p_hold_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_S0 && !hold_ack && !mclr) |=> (state_q == ST_S0));

    p_wait_insert_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_S3 && !ready && !mclr) |=> (state_q == ST_SW));

    p_comp_skip_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_S2 && comp_q && !mclr) |=> (state_q == ST_S4 || state_q == ST_SW));

    p_mm_wait_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_S13 && !ready && !mclr) |=> (state_q == ST_SW1));

    p_mm_halves_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_S14 && !mclr) |=> (state_q == ST_S21));

endmodule

// File: rtl/dma_strobe_dec.sv
module dma_strobe_dec
    import dma_seq_pkg::*;
#(
    parameter int NCH = 4,
    parameter int CHW = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  seq_state_e     state_q,
    input  logic [CHW-1:0] ch_q,
    input  xfer_kind_e     kind_q,
    input  logic           comp_q,
    output logic           hold_req,
    output logic [NCH-1:0] dack,
    output logic           ior,
    output logic           iow,
    output logic           memr,
    output logic           memw,
    output logic           xfer_done,
    output logic [CHW-1:0] done_ch
);

    logic working, pair_on, mm_rd, mm_wr;

    assign working  = (state_q != ST_SI) && (state_q != ST_S0);
    assign hold_req = (state_q != ST_SI);

    assign pair_on = (state_q == ST_S3) || (state_q == ST_SW) || (state_q == ST_S4)
                   || (comp_q && state_q == ST_S2);
    assign mm_rd   = (state_q == ST_S13) || (state_q == ST_SW1) || (state_q == ST_S14);
    assign mm_wr   = (state_q == ST_S23) || (state_q == ST_SW2) || (state_q == ST_S24);

    assign ior  = pair_on && (kind_q == KIND_IO2MEM);
    assign memw = (pair_on && (kind_q == KIND_IO2MEM)) || mm_wr;
    assign memr = (pair_on && (kind_q == KIND_MEM2IO)) || mm_rd;
    assign iow  = pair_on && (kind_q == KIND_MEM2IO);

    assign xfer_done = (state_q == ST_S4) || (state_q == ST_S24);
    assign done_ch   = ch_q;

    generate
        for (genvar g = 0; g < NCH; g++) begin : g_ack
            assign dack[g] = working && (ch_q == CHW'(g));
        end
    endgenerate

    p_dack_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dack));

    p_dack_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|dack) |-> hold_req);

    p_io_pair_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(ior && iow) && !(ior && memr) && !(iow && memw));

    p_mem_split_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(memr && memw));

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> !xfer_done);

endmodule

// File: rtl/dma_bus_seq.sv
module dma_bus_seq
    import dma_seq_pkg::*;
#(
    parameter int NCH = 4,
    parameter int CHW = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           mclr,
    input  logic [NCH-1:0] dreq,
    input  logic [NCH-1:0] dmask,
    input  logic           hold_ack,
    input  logic           ready,
    input  logic           compress,
    input  logic [1:0]     xfer_kind,
    output logic           hold_req,
    output logic [NCH-1:0] dack,
    output logic           ior,
    output logic           iow,
    output logic           memr,
    output logic           memw,
    output logic           xfer_done,
    output logic [CHW-1:0] done_ch
);

    logic           pend;
    logic [CHW-1:0] win_ch;
    seq_state_e     state_q;
    logic [CHW-1:0] ch_q;
    xfer_kind_e     kind_q;
    logic           comp_q;

    dma_req_sample #(.NCH(NCH), .CHW(CHW)) u_smp (
        .clk(clk), .rst_n(rst_n), .dreq(dreq), .dmask(dmask),
        .pend(pend), .win_ch(win_ch)
    );

    dma_seq_fsm #(.CHW(CHW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .mclr(mclr), .pend(pend), .win_ch(win_ch),
        .hold_ack(hold_ack), .ready(ready), .compress(compress),
        .xfer_kind(xfer_kind), .state_q(state_q), .ch_q(ch_q),
        .kind_q(kind_q), .comp_q(comp_q)
    );

    dma_strobe_dec #(.NCH(NCH), .CHW(CHW)) u_dec (
        .clk(clk), .rst_n(rst_n), .state_q(state_q), .ch_q(ch_q),
        .kind_q(kind_q), .comp_q(comp_q), .hold_req(hold_req), .dack(dack),
        .ior(ior), .iow(iow), .memr(memr), .memw(memw),
        .xfer_done(xfer_done), .done_ch(done_ch)
    );

endmodule

// File: tb/tb_dma_bus_seq.sv
module tb_dma_bus_seq;

    localparam int P_IDLE = 0, P_HOLD = 1, P_QUIET = 2, P_STRB = 3, P_END = 4,
                   P_MRD = 5, P_MWR = 6, P_MWR_END = 7;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mclr = 1'b0;
    logic [3:0] dreq = '0;
    logic [3:0] dmask = '0;
    logic       hold_ack = 1'b0;
    logic       ready = 1'b1;
    logic       compress = 1'b0;
    logic [1:0] xfer_kind = 2'b00;
    logic       hold_req, ior, iow, memr, memw, xfer_done;
    logic [3:0] dack;
    logic [1:0] done_ch;

    typedef struct {
        logic [9:0] v;
        logic [1:0] dch;
        string      tag;
    } exp_t;

    exp_t q[$];
    int   n_chk = 0;
    int   n_fail = 0;
    bit   mon_on = 1'b0;
    bit   finished = 1'b0;

    always #5 clk = ~clk;

    dma_bus_seq dut (
        .clk(clk), .rst_n(rst_n), .mclr(mclr), .dreq(dreq), .dmask(dmask),
        .hold_ack(hold_ack), .ready(ready), .compress(compress),
        .xfer_kind(xfer_kind), .hold_req(hold_req), .dack(dack), .ior(ior),
        .iow(iow), .memr(memr), .memw(memw), .xfer_done(xfer_done),
        .done_ch(done_ch)
    );

    // Output vector: {hold_req, dack[3:0], ior, iow, memr, memw, xfer_done}
    function automatic logic [9:0] expv(int ph, int kind, int ch);
        logic       hr = 1'b1, ir = 1'b0, iw = 1'b0, mr = 1'b0, mw = 1'b0, dn = 1'b0;
        logic [3:0] a  = 4'b0001 << ch;
        case (ph)
            P_IDLE: return '0;
            P_HOLD: a = '0;
            P_STRB, P_END: begin
                if (kind == 0) begin ir = 1'b1; mw = 1'b1; end
                if (kind == 1) begin mr = 1'b1; iw = 1'b1; end
                dn = (ph == P_END);
            end
            P_MRD: mr = 1'b1;
            P_MWR: mw = 1'b1;
            P_MWR_END: begin mw = 1'b1; dn = 1'b1; end
            default: ;
        endcase
        return {hr, a, ir, iw, mr, mw, dn};
    endfunction

    task automatic push(int ph, int kind, int ch, string tag);
        exp_t e;
        e.v = expv(ph, kind, ch);
        e.dch = 2'(ch);
        e.tag = tag;
        q.push_back(e);
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic waits(int n, int ph, int kind, int ch, string tag);
        repeat (n) begin
            ready = 1'b0;
            push(ph, kind, ch, tag);
            step();
        end
        ready = 1'b1;
    endtask

    task automatic xfer(logic [3:0] reqv, int ch, int kind, bit comp,
                        int nhold, int nwait, bit pulse, string tag);
        xfer_kind = 2'(kind);
        compress  = comp;
        dreq      = reqv;
        push(P_HOLD, kind, ch, "R4");
        if (pulse) begin
            #4;
            dreq = '0;
        end
        step();
        repeat (nhold) begin
            push(P_HOLD, kind, ch, "R4");
            step();
        end
        hold_ack = 1'b1;
        dreq     = '0;
        if (kind == 2) begin
            push(P_QUIET, kind, ch, tag); step();
            push(P_QUIET, kind, ch, tag); step();
            push(P_MRD, kind, ch, tag);   step();
            waits(nwait, P_MRD, kind, ch, tag);
            push(P_MRD, kind, ch, tag);   step();
            push(P_QUIET, kind, ch, tag); step();
            push(P_QUIET, kind, ch, tag); step();
            push(P_MWR, kind, ch, tag);   step();
            waits(nwait, P_MWR, kind, ch, tag);
            push(P_MWR_END, kind, ch, "R10"); step();
        end else if (comp) begin
            push(P_STRB, kind, ch, tag); step();
            waits(nwait, P_STRB, kind, ch, tag);
            push(P_END, kind, ch, "R10"); step();
        end else begin
            push(P_QUIET, kind, ch, tag); step();
            push(P_QUIET, kind, ch, tag); step();
            push(P_STRB, kind, ch, tag);  step();
            waits(nwait, P_STRB, kind, ch, tag);
            push(P_END, kind, ch, "R10"); step();
        end
        push(P_IDLE, kind, ch, "R10");
        hold_ack = 1'b0;
        step();
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // Monitor: compares every cycle against the scoreboard queue.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (mon_on) begin
                exp_t       e;
                logic [9:0] act;
                act = {hold_req, dack, ior, iow, memr, memw, xfer_done};
                if (q.size() > 0) e = q.pop_front();
                else begin
                    e.v = '0; e.dch = '0; e.tag = "R1";
                end
                n_chk++;
                if (act !== e.v || (e.v[0] && done_ch !== e.dch)) begin
                    n_fail++;
                    $display("FAIL %s: actual outputs %b ch %0d, expected %b ch %0d",
                             e.tag, act, done_ch, e.v, e.dch);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung, expected completion");
        finish_run();
    end

    initial begin
        #12;
        n_chk++;
        if ({hold_req, dack, ior, iow, memr, memw, xfer_done} !== 10'b0) begin
            n_fail++;
            $display("FAIL R1: actual %b, expected all zero in reset",
                     {hold_req, dack, ior, iow, memr, memw, xfer_done});
        end
        step();
        rst_n = 1'b1;
        mon_on = 1'b1;
        step(); step();

        // R5 R8: normal I/O-to-memory on channel 2
        xfer(4'b0100, 2, 0, 1'b0, 2, 0, 1'b0, "R5");
        // R6 R8: normal memory-to-I/O with three waits
        xfer(4'b1000, 3, 1, 1'b0, 0, 3, 1'b0, "R6");
        // R8: no-strobe kind
        xfer(4'b0001, 0, 3, 1'b0, 1, 1, 1'b0, "R8");
        // R7: compressed, no wait and two waits
        xfer(4'b0010, 1, 0, 1'b1, 0, 0, 1'b0, "R7");
        xfer(4'b0010, 1, 1, 1'b1, 1, 2, 1'b0, "R7");
        // R9: memory-to-memory, compress ignored, waits in each half
        xfer(4'b0001, 0, 2, 1'b1, 0, 0, 1'b0, "R9");
        xfer(4'b0100, 2, 2, 1'b0, 1, 2, 1'b0, "R9");
        // R3: lowest channel wins
        xfer(4'b1010, 1, 0, 1'b0, 0, 0, 1'b0, "R3");
        // R3: masked channel skipped
        dmask = 4'b0001;
        xfer(4'b0011, 1, 1, 1'b0, 0, 0, 1'b0, "R3");
        // R3: all masked stays idle
        dmask = 4'hF;
        dreq  = 4'hF;
        repeat (4) begin
            push(P_IDLE, 0, 0, "R3");
            step();
        end
        dreq = '0;
        push(P_IDLE, 0, 0, "R3");
        step();
        dmask = '0;
        step();
        // R2: short pulse across the falling edge only
        xfer(4'b1000, 3, 0, 1'b0, 0, 0, 1'b1, "R2");
        // R1: master clear in the middle of a service
        xfer_kind = 2'b00;
        compress  = 1'b0;
        dreq      = 4'b1000;
        push(P_HOLD, 0, 3, "R4");
        step();
        hold_ack = 1'b1;
        dreq     = '0;
        push(P_QUIET, 0, 3, "R1");
        step();
        mclr = 1'b1;
        push(P_IDLE, 0, 3, "R1");
        step();
        mclr     = 1'b0;
        hold_ack = 1'b0;
        push(P_IDLE, 0, 3, "R1");
        step();
        step(); step();
        mon_on = 1'b0;
        finish_run();
    end

endmodule